// File: doc/BRIEF.md
# Configuration Slot Cache and Loader

This block sits between a CPU and a reconfigurable functional unit. It keeps a
small number of complete fabric configurations in on-chip slots and exposes
exactly one of them, the active slot, to the fabric through a registered read
port. The CPU names the configuration it wants by an identifier. When a valid
slot already carries that identifier, the block switches to it within one clock
and acknowledges.

When no valid slot carries the identifier, the block picks a victim slot. The
victim is an empty slot if there is one. Otherwise it is the slot that was
activated longest ago. The block invalidates the victim and asks memory for the
image. It then writes the returned beats, in order, into the victim. After the
last beat it validates the slot, activates it and acknowledges. A memory error
on any beat ends the load and raises an error pulse. While a load is running,
the block accepts no requests.

Top module: `cfg_cache_loader`

## Requirements
- R1: After reset no configuration is active (`act_valid` = 0, `cfg_rd_data` = 0), `busy`, `req_ack`, `req_err` and `mem_req` are 0, and every slot is empty, so the first request for any identifier is a miss.
- R2: A request accepted while idle, whose identifier matches a valid slot, sets `act_slot` to that slot and `act_id` to the identifier and raises `req_ack` on the following cycle. It raises no `mem_req`.
- R3: A miss raises `mem_req` for exactly one cycle, on the cycle after acceptance, with `mem_req_id` equal to the requested identifier. `busy` is 1 from that cycle until the load ends.
- R4: On a miss the victim is the lowest-numbered empty slot. If no slot is empty, it is the valid slot whose last activation is oldest.
- R5: During a load, beats are taken only on cycles with `mem_rvalid` = 1, and any number of idle cycles may fall between them. Beat k (counting from 0) is stored at index k of the victim. The load completes on exactly the CFG_BEATS-th accepted beat, and never sooner.
- R6: On the cycle after the last beat, the victim is valid and active (`act_slot` = victim, `act_id` = requested identifier), `req_ack` = 1 and `busy` = 0.
- R7: `req_valid` is ignored while `busy` = 1. No memory request, no acknowledge and no change of the loaded identifier result from it.
- R8: A beat with `mem_rvalid` = 1 and `mem_rerr` = 1 aborts the load, even when it is the last beat. On the next cycle `req_err` = 1, `req_ack` = 0 and `busy` = 0, and `act_valid`/`act_slot`/`act_id` are unchanged. The victim stays empty, so a later request for that identifier misses.
- R9: `cfg_rd_data` shows the beat of the active slot at index `cfg_rd_addr`, one cycle after the address is presented. It is 0 while no configuration is active.
- R10: `req_ack` and `req_err` are never 1 in the same cycle. Each request produces exactly one pulse of one of them, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU requests a configuration this cycle |
| req_id | input | ID_W | Identifier of the requested configuration |
| req_ack | output | 1 | One-cycle pulse: requested configuration is now active |
| req_err | output | 1 | One-cycle pulse: load aborted on a memory error |
| busy | output | 1 | Load in progress; requests are ignored |
| mem_req | output | 1 | One-cycle pulse starting a burst read |
| mem_req_id | output | ID_W | Identifier of the image to fetch |
| mem_rvalid | input | 1 | A beat of image data is present |
| mem_rdata | input | BEAT_W | Beat data |
| mem_rerr | input | 1 | Beat carries a memory error |
| act_valid | output | 1 | A configuration is active |
| act_slot | output | $clog2(SLOTS) | Index of the active slot |
| act_id | output | ID_W | Identifier of the active configuration |
| cfg_rd_addr | input | $clog2(CFG_BEATS) | Beat index read from the active slot |
| cfg_rd_data | output | BEAT_W | Beat of the active slot, one cycle after the address |

## Verification
Two events can fall in the same cycle: the final beat of a load and a memory error. The bench therefore aborts loads with the error on the first beat, on a middle beat and on the very last beat. It then requires an error pulse with no acknowledge, an unchanged active slot, and a miss on the next request for that identifier. A second collision comes from requests raised during idle gaps of a load. The bench judges these by the absence of any further memory request or acknowledge, and by the identifier that finally becomes active. Victim choice and slot contents are compared against a timestamp-based model of activation history, and every beat is read back.

// File: rtl/cfg_cache_pkg.sv
package cfg_cache_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_e;

endpackage

// File: rtl/cfg_tag_lru.sv
module cfg_tag_lru #(
    parameter int SLOTS = 4,
    parameter int ID_W  = 8,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] lookup_id,
    output logic            hit,
    output logic [SW-1:0]   hit_slot,
    output logic [SW-1:0]   victim_slot,
    input  logic            claim_en,
    input  logic [SW-1:0]   claim_slot,
    input  logic [ID_W-1:0] claim_id,
    input  logic            fill_en,
    input  logic [SW-1:0]   fill_slot,
    input  logic            touch_en,
    input  logic [SW-1:0]   touch_slot
);

    typedef struct packed {
        logic [SLOTS-1:0]           valid;
        logic [SLOTS-1:0][ID_W-1:0] tag;
        logic [SLOTS-1:0][SW-1:0]   age;
    } dir_t;

    dir_t dir_d, dir_q;
    logic [SLOTS-1:0] match;
    logic             free_found;

    for (genvar g = 0; g < SLOTS; g++) begin : g_match
        assign match[g] = dir_q.valid[g] && (dir_q.tag[g] == lookup_id);
    end

    // hit search and victim choice (empty slot first, else oldest age)
    always_comb begin
        hit         = |match;
        hit_slot    = '0;
        victim_slot = '0;
        free_found  = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = SW'(i);
            if (!dir_q.valid[i]) begin
                victim_slot = SW'(i);
                free_found  = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (dir_q.age[i] == SW'(SLOTS - 1)) victim_slot = SW'(i);
            end
        end
    end

    always_comb begin
        dir_d = dir_q;
        if (claim_en) begin
            dir_d.valid[claim_slot] = 1'b0;
            dir_d.tag[claim_slot]   = claim_id;
        end
        if (fill_en) dir_d.valid[fill_slot] = 1'b1;
        if (touch_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (dir_q.age[i] < dir_q.age[touch_slot]) dir_d.age[i] = dir_q.age[i] + 1'b1;
            end
            dir_d.age[touch_slot] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q.valid <= '0;
            dir_q.tag   <= '0;
            for (int i = 0; i < SLOTS; i++) dir_q.age[i] <= SW'(i);
        end else begin
            dir_q <= dir_d;
        end
    end

    // R2: an identifier never sits in two valid slots
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);

    // R8: a claimed victim is empty on the following cycle
    a_r8_claim_empties: assert property (@(posedge clk) disable iff (!rst_n)
        claim_en |=> !dir_q.valid[$past(claim_slot)]);

endmodule

// File: rtl/cfg_slot_store.sv
module cfg_slot_store #(
    parameter int SLOTS     = 4,
    parameter int CFG_BEATS = 512,
    parameter int BEAT_W    = 128,
    localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW       = (CFG_BEATS > 1) ? $clog2(CFG_BEATS) : 1,
    localparam int DEPTH    = SLOTS * CFG_BEATS,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_slot,
    input  logic [CW-1:0]     wr_idx,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SW-1:0]     rd_slot,
    input  logic [CW-1:0]     rd_idx,
    output logic [BEAT_W-1:0] rd_data
);

    logic [BEAT_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BEAT_W-1:0] rd_d, rd_q;

    assign wr_addr = AW'(int'(wr_slot) * CFG_BEATS + int'(wr_idx));
    assign rd_addr = AW'(int'(rd_slot) * CFG_BEATS + int'(rd_idx));

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_comb begin
        rd_d = '0;
        if (rd_en && (int'(rd_idx) < CFG_BEATS)) rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cfg_cache_loader.sv
module cfg_cache_loader
    import cfg_cache_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int ID_W      = 8,
    parameter int BEAT_W    = 128,
    parameter int CFG_BEATS = 512,
    localparam int SW       = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW       = (CFG_BEATS > 1) ? $clog2(CFG_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_ack,
    output logic              req_err,
    output logic              busy,
    output logic              mem_req,
    output logic [ID_W-1:0]   mem_req_id,
    input  logic              mem_rvalid,
    input  logic [BEAT_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              act_valid,
    output logic [SW-1:0]     act_slot,
    output logic [ID_W-1:0]   act_id,
    input  logic [CW-1:0]     cfg_rd_addr,
    output logic [BEAT_W-1:0] cfg_rd_data
);

    localparam logic [CW-1:0] LAST_BEAT = CW'(CFG_BEATS - 1);

    typedef struct packed {
        ld_state_e       st;
        logic [SW-1:0]   ld_slot;
        logic [CW-1:0]   cnt;
        logic [ID_W-1:0] ld_id;
        logic            act_v;
        logic [SW-1:0]   act_slot;
        logic [ID_W-1:0] act_id;
        logic            ack;
        logic            err;
        logic            mreq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          hit;
    logic [SW-1:0] hit_slot, victim_slot, touch_slot;
    logic          claim_en, fill_en, touch_en, wr_en;

    cfg_tag_lru #(.SLOTS(SLOTS), .ID_W(ID_W)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_id  (req_id),
        .hit        (hit),
        .hit_slot   (hit_slot),
        .victim_slot(victim_slot),
        .claim_en   (claim_en),
        .claim_slot (victim_slot),
        .claim_id   (req_id),
        .fill_en    (fill_en),
        .fill_slot  (ctl_q.ld_slot),
        .touch_en   (touch_en),
        .touch_slot (touch_slot)
    );

    cfg_slot_store #(.SLOTS(SLOTS), .CFG_BEATS(CFG_BEATS), .BEAT_W(BEAT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_slot(ctl_q.ld_slot),
        .wr_idx (ctl_q.cnt),
        .wr_data(mem_rdata),
        .rd_en  (ctl_q.act_v),
        .rd_slot(ctl_q.act_slot),
        .rd_idx (cfg_rd_addr),
        .rd_data(cfg_rd_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ack  = 1'b0;
        ctl_d.err  = 1'b0;
        ctl_d.mreq = 1'b0;
        claim_en   = 1'b0;
        fill_en    = 1'b0;
        touch_en   = 1'b0;
        wr_en      = 1'b0;
        touch_slot = (ctl_q.st == ST_IDLE) ? hit_slot : ctl_q.ld_slot;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (hit) begin
                        touch_en       = 1'b1;
                        ctl_d.act_v    = 1'b1;
                        ctl_d.act_slot = hit_slot;
                        ctl_d.act_id   = req_id;
                        ctl_d.ack      = 1'b1;
                    end else begin
                        claim_en      = 1'b1;
                        ctl_d.st      = ST_LOAD;
                        ctl_d.ld_slot = victim_slot;
                        ctl_d.ld_id   = req_id;
                        ctl_d.cnt     = '0;
                        ctl_d.mreq    = 1'b1;
                    end
                end
            end
            ST_LOAD: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.err = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                        if (ctl_q.cnt == LAST_BEAT) begin
                            fill_en        = 1'b1;
                            touch_en       = 1'b1;
                            ctl_d.st       = ST_IDLE;
                            ctl_d.act_v    = 1'b1;
                            ctl_d.act_slot = ctl_q.ld_slot;
                            ctl_d.act_id   = ctl_q.ld_id;
                            ctl_d.ack      = 1'b1;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_ack    = ctl_q.ack;
    assign req_err    = ctl_q.err;
    assign busy       = (ctl_q.st == ST_LOAD);
    assign mem_req    = ctl_q.mreq;
    assign mem_req_id = ctl_q.ld_id;
    assign act_valid  = ctl_q.act_v;
    assign act_slot   = ctl_q.act_slot;
    assign act_id     = ctl_q.act_id;

    // R3: a memory request opens a load and lasts one cycle
    a_r3_req_opens_load: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $rose(busy));
    a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R5: a load that acknowledges has taken the full beat count
    a_r5_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack && $past(busy)) |-> ($past(ctl_q.cnt) == LAST_BEAT));

    // R6: acknowledge implies an active configuration
    a_r6_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> act_valid);

    // R7: a load only ends with an outcome pulse
    a_r7_load_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (req_ack || req_err));

    // R8: an abort leaves the active configuration alone
    a_r8_abort_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ($stable(act_valid) && $stable(act_slot) && $stable(act_id)));

    // R10: outcome pulses exclude each other
    a_r10_ack_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ack && req_err));

endmodule

// File: tb/cfg_cache_loader_bench.sv
module cfg_cache_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 4;
    localparam int ID_W       = 4;
    localparam int BEAT_W     = 32;
    localparam int CFG_BEATS  = 8;
    localparam int SW         = 2;
    localparam int CW         = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ID_W-1:0]   req_id = '0;
    logic              req_ack, req_err, busy, mem_req;
    logic [ID_W-1:0]   mem_req_id;
    logic              mem_rvalid = 1'b0;
    logic [BEAT_W-1:0] mem_rdata = '0;
    logic              mem_rerr = 1'b0;
    logic              act_valid;
    logic [SW-1:0]     act_slot;
    logic [ID_W-1:0]   act_id;
    logic [CW-1:0]     cfg_rd_addr = '0;
    logic [BEAT_W-1:0] cfg_rd_data;

    int tests = 0;
    int fails = 0;

    // reference model of the slot directory
    bit m_valid [SLOTS];
    int m_tag   [SLOTS];
    int m_stamp [SLOTS];
    int m_now = 0;
    bit m_act_v = 0;
    int m_act_slot = 0;
    int m_act_id = 0;

    cfg_cache_loader #(.SLOTS(SLOTS), .ID_W(ID_W), .BEAT_W(BEAT_W), .CFG_BEATS(CFG_BEATS)) u_cfg_cache_loader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_ack(req_ack), .req_err(req_err), .busy(busy),
        .mem_req(mem_req), .mem_req_id(mem_req_id), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .act_valid(act_valid),
        .act_slot(act_slot), .act_id(act_id), .cfg_rd_addr(cfg_rd_addr),
        .cfg_rd_data(cfg_rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [BEAT_W-1:0] pat(input int id, input int b);
        return BEAT_W'(id * 32'h0101_0000 + b * 32'h0000_0013 + 32'h0000_5A00);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int find_hit(input int id);
        for (int i = 0; i < SLOTS; i++) if (m_valid[i] && m_tag[i] == id) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        int v;
        for (int i = 0; i < SLOTS; i++) if (!m_valid[i]) return i;
        v = 0;
        for (int i = 1; i < SLOTS; i++) if (m_stamp[i] < m_stamp[v]) v = i;
        return v;
    endfunction

    task automatic activate(input int s, input int id);
        m_now++;
        m_stamp[s] = m_now;
        m_act_v = 1;
        m_act_slot = s;
        m_act_id = id;
    endtask

    // one request; err_beat < 0 means a clean load; intrude raises requests in gaps
    task automatic request(input int id, input int err_beat, input bit intrude);
        int h, v;
        bit prev_v;
        int prev_slot, prev_id;
        h = find_hit(id);
        prev_v = m_act_v; prev_slot = m_act_slot; prev_id = m_act_id;
        req_id = ID_W'(id);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (h >= 0) begin
            activate(h, id);
            check(req_ack == 1'b1, "R2 hit ack", req_ack, 1);
            check(act_slot == SW'(h) && act_id == ID_W'(id), "R2 hit slot/id", {act_slot, act_id}, {SW'(h), ID_W'(id)});
            check(mem_req == 1'b0 && busy == 1'b0, "R2 no fetch on hit", {mem_req, busy}, 0);
        end else begin
            v = pick_victim();
            m_valid[v] = 0;
            m_tag[v] = id;
            check(mem_req && busy && !req_ack && mem_req_id == ID_W'(id), "R3 fetch start",
                  {mem_req, busy, req_ack, mem_req_id}, {1'b1, 1'b1, 1'b0, ID_W'(id)});
            for (int b = 0; b < CFG_BEATS; b++) begin
                if (b % 3 == 1) begin
                    mem_rvalid = 1'b0;
                    req_valid = intrude;
                    req_id = ID_W'((id + 5) % 16);
                    @(negedge clk);
                    req_valid = 1'b0;
                    check(!mem_req && !req_ack && !req_err && busy, "R7 request ignored while busy",
                          {mem_req, req_ack, req_err, busy}, 4'b0001);
                end
                mem_rvalid = 1'b1;
                mem_rdata  = pat(id, b);
                mem_rerr   = (b == err_beat);
                @(negedge clk);
                if (b == err_beat) break;
                if (b != CFG_BEATS - 1)
                    check(busy && !req_ack, "R5 no early completion", {busy, req_ack}, 2'b10);
            end
            mem_rvalid = 1'b0;
            mem_rerr = 1'b0;
            if (err_beat >= 0) begin
                check(req_err && !req_ack && !busy, "R8 abort pulse", {req_err, req_ack, busy}, 3'b100);
                check(act_valid == prev_v && (!prev_v || (act_slot == SW'(prev_slot) && act_id == ID_W'(prev_id))),
                      "R8 active unchanged", {act_valid, act_slot, act_id}, {prev_v, SW'(prev_slot), ID_W'(prev_id)});
            end else begin
                m_valid[v] = 1;
                activate(v, id);
                check(req_ack && !busy && !req_err, "R6 load ack", {req_ack, busy, req_err}, 3'b100);
                check(act_valid && act_slot == SW'(v), "R4 victim slot", act_slot, v);
                check(act_id == ID_W'(id), "R6 active id", act_id, id);
            end
        end
        @(negedge clk);
        check(!req_ack && !req_err, "R10 single-cycle outcome", {req_ack, req_err}, 0);
    endtask

    task automatic verify_contents();
        for (int b = 0; b < CFG_BEATS; b++) begin
            cfg_rd_addr = CW'(b);
            @(negedge clk);
            check(cfg_rd_data == pat(m_act_id, b), "R9 read-back", cfg_rd_data, pat(m_act_id, b));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < SLOTS; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_stamp[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!act_valid && !busy && !req_ack && !req_err && !mem_req, "R1 reset outputs",
              {act_valid, busy, req_ack, req_err, mem_req}, 0);
        check(cfg_rd_data == '0, "R1 R9 no data when nothing active", cfg_rd_data, 0);

        request(1, -1, 0); verify_contents();
        request(2, -1, 1); verify_contents();
        request(3, -1, 1);
        request(4, -1, 0); verify_contents();
        request(2, -1, 0); verify_contents();
        request(1, -1, 0);
        request(1, -1, 0);
        request(5, -1, 1); verify_contents();
        // error cases: middle, first, last beat
        request(6, 3, 0);
        request(6, 0, 1);
        request(6, CFG_BEATS - 1, 0);
        request(6, -1, 0); verify_contents();
        // sweep over every identifier, mixing misses, hits and aborts
        for (int r = 0; r < 3; r++) begin
            for (int id = 0; id < 16; id++) begin
                request(id, ((id + r) % 7 == 0) ? (id % CFG_BEATS) : -1, (id % 2) == 1);
                if (id % 4 == r) verify_contents();
                request((id + 15) % 16, -1, 0);
            end
        end
        verify_contents();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule